// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO

A FIFO buffer with separate write and read clocks. Its read timing is chosen once per reset. In standard mode, each word leaves the buffer only when the reader requests it. In fall-through mode, the oldest word moves into an output register by itself. That register then holds one extra word, so the fall-through capacity is one more than the memory depth.

Five status outputs serve the two sides. The read side gets an empty / output-valid indication and a programmable almost-empty flag. The write side gets a full / no-space indication, a half-full flag and a programmable almost-full flag. The almost-empty offset `n` and the almost-full offset `m` have a parameter default. A single load strobe on the write side can overwrite them.

Pointers cross between the clock domains as Gray codes through two-flop synchronizers. Every threshold is compared against the word count in memory. The one-word shift between the two modes therefore comes from the output register alone.

Top module: `dual_mode_fifo`

## Requirements
- R1: The first edge of each clock after `rst_ni` releases samples `mode_i`. 0 selects standard mode and 1 selects fall-through mode. The mode holds until the next reset, and the polarity of `rd_stat_o` and `wr_stat_o` follows it.
- R2: A write takes place on a rising `wclk_i` edge with `wen_ni` low, unless the buffer is full. A write attempted while full changes neither the stored words nor any flag.
- R3: Standard mode, `rd_stat_o`:
  - It is 1 while a word is stored and 0 when the buffer is empty.
  - After a write into an empty buffer, it rises after the second `rclk_i` edge.
  - A `rclk_i` edge with `ren_ni` low and `rd_stat_o` = 1 loads the next word into `rdata_o`.
  - With `rd_stat_o` = 0, `ren_ni` leaves `rdata_o` unchanged.
- R4: Fall-through mode, `rd_stat_o` and `rdata_o`:
  - A word written into an empty buffer appears on `rdata_o` after the third `rclk_i` edge, with no read request.
  - `rd_stat_o` is 0 while `rdata_o` holds a valid word and 1 otherwise.
  - A `rclk_i` edge with `ren_ni` low consumes the word only while `rd_stat_o` = 0. With `rd_stat_o` = 1, `ren_ni` is ignored.
- R5: Full indication on `wr_stat_o`:
  - Standard mode: it goes to 0 once D words are stored.
  - Fall-through mode: it goes to 1 once D+1 words are stored (memory plus output register).
  - In both modes, one read releases it.
- R6: `pae_n_o` is 1 when the stored total is at least n+1 (standard) or n+2 (fall-through), and 0 otherwise.
- R7: `half_n_o` is 0 when the stored total is at least D/2+1 (standard) or D/2+2 (fall-through), and 1 otherwise.
- R8: `paf_n_o` is 0 when the stored total is at least D-m (standard) or D+1-m (fall-through), and 1 otherwise.
- R9: Both offsets reset to `DEF_OFS`. Each `wclk_i` edge with `ld_i` high stores `ofs_i`, alternately into n and m, starting with n after reset.
- R10: Words leave in write order, none lost or repeated, with any mix of reads and writes on unrelated clocks.
- R11: Each pointer crosses domains as a Gray code that changes at most one bit per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Mode select sampled after reset: 0 standard, 1 fall-through |
| wen_ni | input | 1 | Write enable, active low |
| wdata_i | input | DW | Write data |
| ld_i | input | 1 | Offset load strobe |
| ofs_i | input | AW+1 | Offset value for the load strobe |
| wr_stat_o | output | 1 | Standard: 0 = full; fall-through: 1 = full |
| half_n_o | output | 1 | Half-full, active low |
| paf_n_o | output | 1 | Almost-full, active low |
| rclk_i | input | 1 | Read clock |
| ren_ni | input | 1 | Read enable, active low |
| rdata_o | output | DW | Read data |
| rd_stat_o | output | 1 | Standard: 0 = empty; fall-through: 0 = output valid |
| pae_n_o | output | 1 | Almost-empty, active low |

## Verification
A wrong pointer or count shows up as a flag that toggles one word early or late. The bench fills to capacity and then drains back to zero, checking after every word, so the fault is exposed at that word. A lost or duplicated word, or a blocked write that slipped into memory, shows up as a data mismatch on the next read that reaches the affected slot. A wrong output-register state in fall-through mode shows up as a wrong latency: the word appears before or after the third read edge. It can also show up as a word held or consumed in the wrong cycle, which breaks the data order on the following read.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} mode_e;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/dmf_gray_sync.sv
module dmf_gray_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= gray_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      acc      = acc ^ stg_q[STAGES-1][i];
      bin_o[i] = acc;
    end
  end
endmodule

// File: rtl/dmf_wr_side.sv
module dmf_wr_side
  import dmf_pkg::*;
#(
  parameter int unsigned AW      = 4,
  parameter int unsigned DEF_OFS = 3,
  localparam int unsigned PW     = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          wen_ni,
  input  logic          ld_i,
  input  logic [PW-1:0] ofs_i,
  input  logic [PW-1:0] rptr_bin_i,
  output logic [PW-1:0] wptr_gray_o,
  output logic [AW-1:0] waddr_o,
  output logic          we_o,
  output logic [PW-1:0] empty_ofs_o,
  output logic          wr_stat_o,
  output logic          half_n_o,
  output logic          paf_n_o
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned SW    = PW + 1;

  logic          init_q;
  mode_e         mode_q;
  logic [PW-1:0] wptr_q, wgray_q, wptr_nx, wcnt;
  logic [PW-1:0] eofs_q, fofs_q;
  logic          sel_q, full, push;
  logic [SW-1:0] paf_sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b1;
      mode_q <= MODE_STD;
    end else if (init_q) begin
      init_q <= 1'b0;
      mode_q <= mode_e'(mode_i);
    end
  end

  assign wcnt    = wptr_q - rptr_bin_i;
  assign full    = (wcnt == PW'(DEPTH));
  assign push    = !wen_ni && !full && !init_q;
  assign wptr_nx = wptr_q + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      wgray_q <= '0;
    end else if (push) begin
      wptr_q  <= wptr_nx;
      wgray_q <= wptr_nx ^ (wptr_nx >> 1);
    end
  end

  // offset loads alternate: empty offset first, then full offset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eofs_q <= PW'(DEF_OFS);
      fofs_q <= PW'(DEF_OFS);
      sel_q  <= 1'b0;
    end else if (ld_i) begin
      if (!sel_q) eofs_q <= ofs_i;
      else        fofs_q <= ofs_i;
      sel_q <= ~sel_q;
    end
  end

  assign paf_sum     = {1'b0, wcnt} + {1'b0, fofs_q};
  assign wr_stat_o   = (mode_q == MODE_FWFT) ? full : !full;
  assign half_n_o    = !(wcnt > PW'(DEPTH / 2));
  assign paf_n_o     = !(paf_sum >= SW'(DEPTH));
  assign we_o        = push;
  assign waddr_o     = wptr_q[AW-1:0];
  assign wptr_gray_o = wgray_q;
  assign empty_ofs_o = eofs_q;

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcnt <= PW'(DEPTH));
  assert_gray_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
  assert_mode_fixed_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_q |=> $stable(mode_q));
endmodule

// File: rtl/dmf_rd_side.sv
module dmf_rd_side
  import dmf_pkg::*;
#(
  parameter int unsigned DW  = 36,
  parameter int unsigned AW  = 4,
  localparam int unsigned PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          ren_ni,
  input  logic [PW-1:0] wptr_bin_i,
  input  logic [PW-1:0] empty_ofs_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [PW-1:0] rptr_gray_o,
  output logic [DW-1:0] rdata_o,
  output logic          rd_stat_o,
  output logic          pae_n_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic          init_q, ovld_q, mem_empty, pop, fwft;
  mode_e         mode_q;
  logic [PW-1:0] rptr_q, rgray_q, rptr_nx, rcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b1;
      mode_q <= MODE_STD;
    end else if (init_q) begin
      init_q <= 1'b0;
      mode_q <= mode_e'(mode_i);
    end
  end

  assign fwft      = (mode_q == MODE_FWFT);
  assign rcnt      = wptr_bin_i - rptr_q;
  assign mem_empty = (rcnt == '0);
  assign rptr_nx   = rptr_q + PW'(1);

  // fall-through refills the output register whenever it is free or being consumed
  always_comb begin
    if (init_q)    pop = 1'b0;
    else if (fwft) pop = !mem_empty && (!ovld_q || !ren_ni);
    else           pop = !mem_empty && !ren_ni;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      rgray_q <= '0;
      rdata_o <= '0;
      ovld_q  <= 1'b0;
    end else begin
      if (pop) begin
        rptr_q  <= rptr_nx;
        rgray_q <= rptr_nx ^ (rptr_nx >> 1);
        rdata_o <= mem_rdata_i;
      end
      if (fwft) begin
        if (pop)          ovld_q <= 1'b1;
        else if (!ren_ni) ovld_q <= 1'b0;
      end
    end
  end

  assign rd_stat_o   = fwft ? !ovld_q : !mem_empty;
  assign pae_n_o     = (rcnt > empty_ofs_i);
  assign raddr_o     = rptr_q[AW-1:0];
  assign rptr_gray_o = rgray_q;

  assert_no_underflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rcnt <= PW'(DEPTH));
  assert_gray_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);
  assert_mode_fixed_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_q |=> $stable(mode_q));
  assert_empty_read_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_q && !fwft && !rd_stat_o && !ren_ni) |=> $stable(rdata_o));
  assert_head_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_q && fwft && !rd_stat_o && ren_ni) |=> ($stable(rdata_o) && !rd_stat_o));
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
  import dmf_pkg::*;
#(
  parameter int unsigned DW      = 36,
  parameter int unsigned AW      = 4,
  parameter int unsigned DEF_OFS = 3
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          wen_ni,
  input  logic [DW-1:0] wdata_i,
  input  logic          ld_i,
  input  logic [AW:0]   ofs_i,
  output logic          wr_stat_o,
  output logic          half_n_o,
  output logic          paf_n_o,
  input  logic          rclk_i,
  input  logic          ren_ni,
  output logic [DW-1:0] rdata_o,
  output logic          rd_stat_o,
  output logic          pae_n_o
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned PW    = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wgray, rgray, wbin_rd, rbin_wr, eofs;
  logic [AW-1:0] waddr, raddr;
  logic          we;
  logic [DW-1:0] mem_rdata;

  dmf_wr_side #(.AW(AW), .DEF_OFS(DEF_OFS)) i_wr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .mode_i(mode_i), .wen_ni(wen_ni),
    .ld_i(ld_i), .ofs_i(ofs_i), .rptr_bin_i(rbin_wr), .wptr_gray_o(wgray),
    .waddr_o(waddr), .we_o(we), .empty_ofs_o(eofs), .wr_stat_o(wr_stat_o),
    .half_n_o(half_n_o), .paf_n_o(paf_n_o)
  );

  dmf_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) i_sync_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .gray_i(wgray), .bin_o(wbin_rd)
  );

  dmf_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) i_sync_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .gray_i(rgray), .bin_o(rbin_wr)
  );

  always_ff @(posedge wclk_i) begin
    if (we) mem[waddr] <= wdata_i;
  end

  assign mem_rdata = mem[raddr];

  // offsets are loaded while idle, so the read side uses them without a synchronizer
  dmf_rd_side #(.DW(DW), .AW(AW)) i_rd (
    .clk_i(rclk_i), .rst_ni(rst_ni), .mode_i(mode_i), .ren_ni(ren_ni),
    .wptr_bin_i(wbin_rd), .empty_ofs_i(eofs), .mem_rdata_i(mem_rdata),
    .raddr_o(raddr), .rptr_gray_o(rgray), .rdata_o(rdata_o),
    .rd_stat_o(rd_stat_o), .pae_n_o(pae_n_o)
  );
endmodule

// File: tb/test_dual_mode_fifo.sv
`timescale 1ns/100ps
module test_dual_mode_fifo;
  localparam int unsigned DW = 36, AW = 4, DEPTH = 16, DEF_OFS = 3, NW = 1200;

  logic          wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0, mode = 1'b0;
  logic          wen_n = 1'b1, ld = 1'b0, ren_n = 1'b1;
  logic [DW-1:0] wdata = '0;
  logic [AW:0]   ofs = '0;
  logic          wr_stat, half_n, paf_n, rd_stat, pae_n;
  logic [DW-1:0] rdata;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [DW-1:0] q[$];

  initial forever #2 wclk = ~wclk;
  initial begin
    #1.3;
    forever #3.5 rclk = ~rclk;
  end

  dual_mode_fifo #(.DW(DW), .AW(AW), .DEF_OFS(DEF_OFS)) i_dual_mode_fifo (
    .wclk_i(wclk), .rst_ni(rst_n), .mode_i(mode), .wen_ni(wen_n), .wdata_i(wdata),
    .ld_i(ld), .ofs_i(ofs), .wr_stat_o(wr_stat), .half_n_o(half_n), .paf_n_o(paf_n),
    .rclk_i(rclk), .ren_ni(ren_n), .rdata_o(rdata), .rd_stat_o(rd_stat), .pae_n_o(pae_n)
  );

  task automatic chk1(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic chkd(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // expected flags from the stored total k
  function automatic logic f_rd(bit fw, int k);
    return fw ? (k == 0) : (k != 0);
  endfunction
  function automatic logic f_wr(bit fw, int k);
    return fw ? (k >= DEPTH + 1) : !(k >= DEPTH);
  endfunction
  function automatic logic f_half(bit fw, int k);
    return fw ? !(k >= DEPTH / 2 + 2) : !(k >= DEPTH / 2 + 1);
  endfunction
  function automatic logic f_paf(bit fw, int k, int m);
    return fw ? !(k >= DEPTH + 1 - m) : !(k >= DEPTH - m);
  endfunction
  function automatic logic f_pae(bit fw, int k, int n);
    return fw ? (k >= n + 2) : (k >= n + 1);
  endfunction

  task automatic check_flags(input bit fw, input int k, input int n, input int m);
    chk1($sformatf("%s k=%0d", fw ? "R4 output-ready" : "R3 empty flag", k), rd_stat, f_rd(fw, k));
    chk1($sformatf("R5 full indication k=%0d", k), wr_stat, f_wr(fw, k));
    chk1($sformatf("R7 half-full k=%0d", k), half_n, f_half(fw, k));
    chk1($sformatf("R8 almost-full k=%0d", k), paf_n, f_paf(fw, k, m));
    chk1($sformatf("R6 almost-empty k=%0d", k), pae_n, f_pae(fw, k, n));
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
    repeat (4) @(negedge wclk);
  endtask

  task automatic do_reset(input bit fw);
    @(negedge wclk);
    rst_n = 1'b0; mode = fw; wen_n = 1'b1; ren_n = 1'b1; ld = 1'b0;
    q.delete();
    repeat (3) @(negedge wclk);
    rst_n = 1'b1;
    repeat (4) @(negedge rclk);
    repeat (4) @(negedge wclk);
  endtask

  task automatic wr1(input logic [DW-1:0] d, input bit keep);
    @(negedge wclk);
    wen_n = 1'b0; wdata = d;
    if (keep) q.push_back(d);
    @(negedge wclk);
    wen_n = 1'b1;
  endtask

  task automatic rd1(input bit fw);
    if (fw) begin
      @(negedge rclk);
      chkd("R10 fall-through order", rdata, q[0]);
      void'(q.pop_front());
      ren_n = 1'b0;
      @(negedge rclk);
      ren_n = 1'b1;
    end else begin
      @(negedge rclk);
      ren_n = 1'b0;
      @(negedge rclk);
      ren_n = 1'b1;
      chkd("R10 standard order", rdata, q.pop_front());
    end
  endtask

  task automatic load_ofs(input logic [AW:0] v);
    @(negedge wclk);
    ld = 1'b1; ofs = v;
    @(negedge wclk);
    ld = 1'b0;
  endtask

  task automatic latency_test(input bit fw, input int n, input int m);
    logic [DW-1:0] w;
    w = DW'(36'h5A5A0F0F1);
    @(negedge wclk);
    wen_n = 1'b0; wdata = w; q.push_back(w);
    @(posedge wclk);
    #0.5 wen_n = 1'b1;
    @(posedge rclk); @(negedge rclk);
    chk1(fw ? "R4 not valid after 1 edge" : "R3 still empty after 1 edge", rd_stat, fw ? 1'b1 : 1'b0);
    @(posedge rclk); @(negedge rclk);
    chk1(fw ? "R4 not valid after 2 edges" : "R3 not empty after 2 edges", rd_stat, 1'b1);
    if (fw) begin
      @(posedge rclk); @(negedge rclk);
      chk1("R4 valid after 3 edges", rd_stat, 1'b0);
      chkd("R4 head word without read", rdata, w);
    end
    rd1(fw);
    settle();
    check_flags(fw, 0, n, m);
  endtask

  task automatic fill_drain(input bit fw, input int n, input int m);
    int cap;
    logic [DW-1:0] hold;
    cap = DEPTH + (fw ? 1 : 0);
    for (int k = 1; k <= cap; k++) begin
      wr1(DW'(36'h100000000) + DW'(k) + (fw ? DW'(36'h800) : DW'(0)), 1'b1);
      settle();
      check_flags(fw, k, n, m);
    end
    wr1(DW'(36'hBADBADBAD), 1'b0);
    settle();
    chk1("R2 blocked write keeps full", wr_stat, f_wr(fw, cap));
    check_flags(fw, cap, n, m);
    for (int k = cap; k >= 1; k--) begin
      rd1(fw);
      settle();
      check_flags(fw, k - 1, n, m);
    end
    hold = rdata;
    @(negedge rclk);
    ren_n = 1'b0;
    repeat (3) @(negedge rclk);
    ren_n = 1'b1;
    settle();
    chkd(fw ? "R4 read on empty ignored" : "R3 read on empty ignored", rdata, hold);
    check_flags(fw, 0, n, m);
    wr1(DW'(36'h0C0FFEE00), 1'b1);
    settle();
    rd1(fw);
    settle();
    check_flags(fw, 0, n, m);
  endtask

  task automatic run_random(input bit fw, input int n, input int m);
    int sent, rx;
    bit pend;
    sent = 0; rx = 0; pend = 1'b0;
    fork
      begin
        while (sent < NW) begin
          bit space, slow;
          @(negedge wclk);
          space = fw ? !wr_stat : wr_stat;
          slow  = ((sent / 200) % 2) == 1;
          if (space && (slow ? ($urandom_range(7) == 0) : ($urandom_range(3) != 0))) begin
            wen_n = 1'b0;
            wdata = DW'({$urandom(), $urandom()});
            q.push_back(wdata);
            sent++;
          end else if (!space && $urandom_range(1) == 1) begin
            wen_n = 1'b0;
            wdata = '1;
          end else begin
            wen_n = 1'b1;
          end
        end
        @(negedge wclk);
        wen_n = 1'b1;
      end
      begin
        while (rx < NW) begin
          @(negedge rclk);
          if (!fw) begin
            if (pend) begin
              chkd("R10 R11 random order", rdata, q.pop_front());
              rx++;
              pend = 1'b0;
            end
            if (rx >= NW) ren_n = 1'b1;
            else if (rd_stat && $urandom_range(2) != 0) begin
              ren_n = 1'b0; pend = 1'b1;
            end else if (!rd_stat && $urandom_range(1) == 1) ren_n = 1'b0;
            else ren_n = 1'b1;
          end else begin
            if (!rd_stat && $urandom_range(2) != 0) begin
              chkd("R10 R11 random order", rdata, q[0]);
              void'(q.pop_front());
              rx++;
              ren_n = 1'b0;
            end else if (rd_stat && $urandom_range(1) == 1) ren_n = 1'b0;
            else ren_n = 1'b1;
          end
        end
        @(negedge rclk);
        ren_n = 1'b1;
      end
    join
    settle();
    chk1("R10 model drained", q.size() == 0, 1'b1);
    check_flags(fw, 0, n, m);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // standard mode with default offsets
    do_reset(1'b0);
    chk1("R1 standard polarity at reset", rd_stat, 1'b0);
    chkd("R3 data reset value", rdata, '0);
    check_flags(1'b0, 0, DEF_OFS, DEF_OFS);
    latency_test(1'b0, DEF_OFS, DEF_OFS);
    fill_drain(1'b0, DEF_OFS, DEF_OFS);
    run_random(1'b0, DEF_OFS, DEF_OFS);
    // fall-through mode, offsets loaded: n=9, m=2, then n rewritten to 5 (R9)
    do_reset(1'b1);
    chk1("R1 fall-through polarity at reset", rd_stat, 1'b1);
    chk1("R1 fall-through no-space idle", wr_stat, 1'b0);
    load_ofs(5'd9);
    load_ofs(5'd2);
    load_ofs(5'd5);
    settle();
    check_flags(1'b1, 0, 5, 2);
    latency_test(1'b1, 5, 2);
    fill_drain(1'b1, 5, 2);
    run_random(1'b1, 5, 2);
    // back to standard: mode follows the new reset (R1), offsets back to default (R9)
    do_reset(1'b0);
    chk1("R1 mode re-sampled", rd_stat, 1'b0);
    fill_drain(1'b0, DEF_OFS, DEF_OFS);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge wclk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule